// File: doc/BRIEF.md
# Egress Descriptor Ring Consumer

The block reads 128-bit egress descriptors, one slot at a time, from a circular ring that software fills in local memory. Ownership of a slot is decided by a single phase bit inside the descriptor. Software flips the phase it writes each time its own write position wraps around the ring. The consumer therefore accepts a slot only when the slot's phase bit equals the phase it currently expects. Until that happens it keeps re-reading the same slot, so software never has to touch a pointer register.

For every accepted descriptor the block decodes the control flags and presents one transfer command downstream over a valid/ready handshake. The command carries a byte count, start-of-packet and end-of-packet marks, a skip mark and the buffer information. A descriptor with a non-zero reserved bit is reported on an error strobe and is turned into a skip. A notification strobe accompanies the acceptance of any descriptor that asks for one. Moving the data and following buffer chains are left to the logic downstream.

Top module: `egress_ring_consumer`

## Requirements
- R1: While and right after reset, cmd_valid_o, notif_o and err_o are low. The expected phase is 1, and the first read is issued to slot 0.
- R2: A read descriptor is accepted only when its bit 0 equals the expected phase. Otherwise no command is issued and the same slot is read again. No read is issued while a command is pending.
- R3: The read slot advances by one for each accepted command and wraps from DEPTH-1 to 0. The expected phase inverts on every wrap.
- R4: For a descriptor that is not skipped, cmd_bytes_o equals descriptor bits [17:4], a 14-bit transfer size, and cmd_buf_o equals bits [95:32].
- R5: cmd_eop_o equals descriptor bit 2, the packet boundary flag.
- R6: cmd_sop_o is 1 on the first command after reset and on the command after any command whose cmd_eop_o was 1, and 0 otherwise.
- R7: When descriptor bit 1, the nothing-to-send flag, is set, the command has cmd_skip_o=1, cmd_bytes_o=0 and cmd_buf_o=0, and the slot is still consumed.
- R8: A transfer size of zero gives cmd_skip_o=1 and cmd_buf_o=0, so the buffer information is ignored.
- R9: If any reserved bit ([31:18] or [127:96]) is non-zero, err_o is high during that command's handshake cycle, and the command is a skip with zero bytes and zero buffer information.
- R10: notif_o is high exactly in the handshake cycle of a command whose descriptor has bit 3, the notify flag, set. It is never high outside a handshake.
- R11: While cmd_valid_o is high and cmd_ready_i is low, the command stays valid and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_o | output | 1 | One-cycle read request for a ring slot |
| rd_idx_o | output | IDX_W | Slot index being read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 128 | Descriptor read from the ring |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Downstream accepts the command |
| cmd_bytes_o | output | 14 | Bytes to move |
| cmd_buf_o | output | 64 | Buffer information |
| cmd_sop_o | output | 1 | First command of a packet |
| cmd_eop_o | output | 1 | Last command of a packet |
| cmd_skip_o | output | 1 | Consume without moving data |
| notif_o | output | 1 | Completion notification strobe |
| err_o | output | 1 | Reserved-bit error strobe |

## Verification
A four-slot ring is fed 48 descriptors over twelve laps. Their sizes, flags and reserved-bit faults follow modular patterns, so every combination of skip, zero size, maximum size, boundary, notify and error turns up in both phases. This separates decode mistakes from ownership mistakes. The producer pauses twice, once inside a lap and once at a lap start where the stale slot holds the previous lap's phase. These pauses show whether the consumer polls and stalls, or instead overruns stale entries after a wrap. A ready pattern that drops one cycle in five exposes any command fields that change before acceptance.

// File: rtl/ring_cons_pkg.sv
package ring_cons_pkg;
  localparam int DESC_W     = 128;
  localparam int SIZE_W     = 14;
  localparam int BUF_W      = 64;
  localparam int PHASE_BIT  = 0;
  localparam int SKIP_BIT   = 1;
  localparam int LAST_BIT   = 2;
  localparam int NOTE_BIT   = 3;
  localparam int SIZE_LSB   = 4;
  localparam int RSV_LO_LSB = SIZE_LSB + SIZE_W;
  localparam int RSV_LO_W   = 32 - RSV_LO_LSB;
  localparam int BUF_LSB    = 32;
  localparam int RSV_HI_LSB = BUF_LSB + BUF_W;
  localparam int RSV_HI_W   = DESC_W - RSV_HI_LSB;

  typedef struct packed {
    logic              phase;
    logic              skip;
    logic              last;
    logic              notify;
    logic              rsv_err;
    logic [SIZE_W-1:0] bytes;
    logic [BUF_W-1:0]  buf_info;
  } dec_t;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             phase_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      phase_o <= 1'b1;
    end else if (adv_i) begin
      if (idx_o == LAST) begin
        idx_o   <= '0;
        phase_o <= ~phase_o;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && idx_o == LAST |=> idx_o == '0 && phase_o != $past(phase_o));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && idx_o != LAST |=> idx_o == IDX_W'($past(idx_o) + 1'b1) && $stable(phase_o));
  assert_hold_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_o) && $stable(phase_o));
endmodule

// File: rtl/desc_decode.sv
module desc_decode
  import ring_cons_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.phase    = desc_i[PHASE_BIT];
    dec_o.skip     = desc_i[SKIP_BIT];
    dec_o.last     = desc_i[LAST_BIT];
    dec_o.notify   = desc_i[NOTE_BIT];
    dec_o.bytes    = desc_i[SIZE_LSB +: SIZE_W];
    dec_o.buf_info = desc_i[BUF_LSB +: BUF_W];
    dec_o.rsv_err  = (|desc_i[RSV_LO_LSB +: RSV_LO_W]) | (|desc_i[RSV_HI_LSB +: RSV_HI_W]);
  end
endmodule

// File: rtl/egress_ring_consumer.sv
module egress_ring_consumer
  import ring_cons_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_req_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [DESC_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [SIZE_W-1:0] cmd_bytes_o,
  output logic [BUF_W-1:0]  cmd_buf_o,
  output logic              cmd_sop_o,
  output logic              cmd_eop_o,
  output logic              cmd_skip_o,
  output logic              notif_o,
  output logic              err_o
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_ISSUE} state_e;

  state_e state_q;
  dec_t   dec;
  logic   phase;
  logic   adv;
  logic   sop_pend_q;
  logic   notify_q;
  logic   err_q;
  logic   drop;

  ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .idx_o  (rd_idx_o),
    .phase_o(phase)
  );

  desc_decode u_dec (
    .desc_i(rd_data_i),
    .dec_o (dec)
  );

  assign adv         = (state_q == S_ISSUE) && cmd_ready_i;
  assign rd_req_o    = (state_q == S_FETCH);
  assign cmd_valid_o = (state_q == S_ISSUE);
  assign notif_o     = adv && notify_q;
  assign err_o       = adv && err_q;
  // reserved-bit faults and empty sizes collapse into a skip
  assign drop        = dec.skip || dec.rsv_err || (dec.bytes == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      sop_pend_q  <= 1'b1;
      notify_q    <= 1'b0;
      err_q       <= 1'b0;
      cmd_bytes_o <= '0;
      cmd_buf_o   <= '0;
      cmd_sop_o   <= 1'b0;
      cmd_eop_o   <= 1'b0;
      cmd_skip_o  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE:  state_q <= S_FETCH;
        S_FETCH: state_q <= S_WAIT;
        S_WAIT: begin
          if (rd_valid_i) begin
            if (dec.phase == phase) begin
              cmd_bytes_o <= drop ? '0 : dec.bytes;
              cmd_buf_o   <= drop ? '0 : dec.buf_info;
              cmd_skip_o  <= drop;
              cmd_eop_o   <= dec.last;
              cmd_sop_o   <= sop_pend_q;
              notify_q    <= dec.notify;
              err_q       <= dec.rsv_err;
              state_q     <= S_ISSUE;
            end else begin
              state_q <= S_FETCH;
            end
          end
        end
        S_ISSUE: begin
          if (cmd_ready_i) begin
            sop_pend_q <= cmd_eop_o;
            state_q    <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_bytes_o) && $stable(cmd_buf_o)
      && $stable(cmd_sop_o) && $stable(cmd_eop_o) && $stable(cmd_skip_o));
  assert_notif_hs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notif_o |-> cmd_valid_o && cmd_ready_i);
  assert_err_skip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cmd_skip_o && cmd_bytes_o == '0 && cmd_buf_o == '0);
  assert_no_fetch_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !cmd_valid_o);
  assert_skip_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_skip_o |-> cmd_bytes_o == '0 && cmd_buf_o == '0);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) && $past(state_q == S_IDLE) |-> rd_idx_o == '0 && phase);
endmodule

// File: tb/egress_ring_consumer_tb.sv
`timescale 1ns/1ps
module egress_ring_consumer_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NDESC = 48;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_req_o;
  logic [IDX_W-1:0]  rd_idx_o;
  logic              rd_valid_i = 1'b0;
  logic [127:0]      rd_data_i = '0;
  logic              cmd_valid_o;
  logic              cmd_ready_i = 1'b0;
  logic [13:0]       cmd_bytes_o;
  logic [63:0]       cmd_buf_o;
  logic              cmd_sop_o, cmd_eop_o, cmd_skip_o, notif_o, err_o;

  logic [127:0] mem [DEPTH];
  int n_run = 0, n_fail = 0, consumed = 0, req_cnt = 0, spurious = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  egress_ring_consumer #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_bytes_o(cmd_bytes_o), .cmd_buf_o(cmd_buf_o),
    .cmd_sop_o(cmd_sop_o), .cmd_eop_o(cmd_eop_o), .cmd_skip_o(cmd_skip_o),
    .notif_o(notif_o), .err_o(err_o)
  );

  // ring memory, one-cycle read latency
  always @(posedge clk_i) begin
    rd_valid_i <= rd_req_o && rst_ni;
    rd_data_i  <= mem[rd_idx_o];
  end

  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      cyc = cyc + 1;
      cmd_ready_i = (cyc % 5) != 3;
    end
  end

  function automatic logic [13:0] size_of(int k);
    case (k % 6)
      0: return 14'd0;
      1: return 14'd16383;
      2: return 14'd1;
      default: return 14'((k * 517) % 16384);
    endcase
  endfunction
  function automatic bit skip_f(int k);   return (k % 5) == 2; endfunction
  function automatic bit bound_f(int k);  return (k % 3) == 2; endfunction
  function automatic bit note_f(int k);   return (k % 4) == 1; endfunction
  function automatic bit err_f(int k);    return (k % 7) == 3; endfunction
  function automatic logic [63:0] buf_f(int k);
    return {32'hB000_0000 + 32'(k), 32'h0000_C000 + 32'(3 * k)};
  endfunction

  function automatic logic [127:0] gen_desc(int k);
    logic [127:0] d;
    d = '0;
    d[0]     = ((k / DEPTH) % 2) == 0;
    d[1]     = skip_f(k);
    d[2]     = bound_f(k);
    d[3]     = note_f(k);
    d[17:4]  = size_of(k);
    d[95:32] = buf_f(k);
    if (err_f(k)) begin
      if (k % 2 == 0) d[18 + (k % 14)] = 1'b1;
      else            d[96 + (k % 32)] = 1'b1;
    end
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic        held = 1'b0;
  logic [13:0] held_bytes;
  logic [63:0] held_buf;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(cmd_valid_o == 1'b0, "R1 cmd_valid in reset", 64'(cmd_valid_o), 0);
    chk(notif_o == 1'b0 && err_o == 1'b0, "R1 strobes in reset", 64'({notif_o, err_o}), 0);
    rst_ni = 1'b1;
    fork
      begin : producer
        for (int k = 0; k < NDESC; k++) begin
          while (k >= consumed + DEPTH) @(negedge clk_i);
          if (k == 3 || k == 8) begin
            int r0;
            @(negedge clk_i);
            r0 = req_cnt;
            repeat (80) @(negedge clk_i);
            chk(consumed == k, "R2 stalls on stale slot", 64'(consumed), 64'(k));
            chk(cmd_valid_o == 1'b0, "R2 no command while stalled", 64'(cmd_valid_o), 0);
            chk(req_cnt - r0 >= 10, "R2 slot polled while stalled", 64'(req_cnt - r0), 10);
          end
          @(negedge clk_i);
          mem[k % DEPTH] = gen_desc(k);
        end
        while (consumed < NDESC) @(negedge clk_i);
        repeat (40) @(negedge clk_i);
        chk(consumed == NDESC, "R3 no extra commands after ring drained", 64'(consumed), 64'(NDESC));
        chk(spurious == 0, "R10 no strobe outside handshake", 64'(spurious), 0);
      end
      begin : monitor
        forever begin
          @(negedge clk_i);
          if (rd_req_o) begin
            req_cnt = req_cnt + 1;
            chk(rd_idx_o == IDX_W'(consumed % DEPTH), "R3 read slot", 64'(rd_idx_o), 64'(consumed % DEPTH));
          end
          if (held) begin
            chk(cmd_valid_o && cmd_bytes_o == held_bytes && cmd_buf_o == held_buf,
                "R11 command held", 64'(cmd_bytes_o), 64'(held_bytes));
          end
          held = cmd_valid_o && !cmd_ready_i;
          held_bytes = cmd_bytes_o;
          held_buf = cmd_buf_o;
          if (cmd_valid_o && cmd_ready_i) begin
            int k;
            bit skp;
            k = consumed;
            skp = skip_f(k) || err_f(k) || size_of(k) == 14'd0;
            if (skp) begin
              chk(cmd_skip_o == 1'b1, err_f(k) ? "R9 skip on reserved" :
                  (skip_f(k) ? "R7 skip flag" : "R8 zero size skip"), 64'(cmd_skip_o), 1);
              chk(cmd_bytes_o == 14'd0, "R7 skipped bytes", 64'(cmd_bytes_o), 0);
              chk(cmd_buf_o == 64'd0, "R8 skipped buffer info", cmd_buf_o, 0);
            end else begin
              chk(cmd_skip_o == 1'b0, "R4 not skipped", 64'(cmd_skip_o), 0);
              chk(cmd_bytes_o == size_of(k), "R4 bytes", 64'(cmd_bytes_o), 64'(size_of(k)));
              chk(cmd_buf_o == buf_f(k), "R4 buffer info", cmd_buf_o, buf_f(k));
            end
            chk(cmd_eop_o == bound_f(k), "R5 eop", 64'(cmd_eop_o), 64'(bound_f(k)));
            chk(cmd_sop_o == (k == 0 || bound_f(k - 1)), "R6 sop", 64'(cmd_sop_o),
                64'(k == 0 || bound_f(k - 1)));
            chk(notif_o == note_f(k), "R10 notify", 64'(notif_o), 64'(note_f(k)));
            chk(err_o == err_f(k), "R9 error strobe", 64'(err_o), 64'(err_f(k)));
            consumed = consumed + 1;
          end else if (notif_o || err_o) begin
            spurious = spurious + 1;
          end
        end
      end
      begin : watchdog
        repeat (100000) @(posedge clk_i);
        n_run = n_run + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog consumed=%0d expected=%0d", consumed, NDESC);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule